// File: doc/BRIEF.md
# Trace Capture Circular Buffer

This block is an on-chip sink for a stream of 32-bit trace words. While capture is active, every accepted word goes into an internal RAM that is used as a ring. A write pointer advances through the RAM and wraps back to zero at the end. When the RAM fills, the oldest words are overwritten, and a sticky flag records that a wrap happened. After capture stops, software drains the stored words through a data register. Each read of that register returns one word and moves the read pointer forward.

Capture ends in one of two ways. Software can issue a flush-and-stop command, or capture stops by itself a programmed number of words after a trigger input fires. Either way, a word already inside the input stage is written before the block reports ready again. A mode bit turns the block into a pass-through, in which accepted words leave on a streaming output and the RAM is not used.

Software can move both pointers while the block is idle. A new read-pointer value is rounded down to a frame boundary, and the count of unread data is recomputed from the pointer distance.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset the block is idle and ready. Register index 2 (status) reads 1: bit 0 is ready, bit 1 is full, bit 2 is triggered. Index 4 (read pointer), index 5 (write pointer), index 7 (word count) and index 1 (mode) all read 0.
- R2: Writing 1 to bit 0 of index 0 (control) while ready starts capture. The start clears both pointers, the full flag, the word count and the triggered flag. Status bit 0 reads 0 for as long as capture runs.
- R3: In ring mode, each trace word accepted while capture runs is stored at the write pointer. The write pointer advances by 4 bytes, modulo the RAM size, and the word count grows by one.
- R4: When the write pointer wraps from the last word to 0, the full flag (status bit 1) is set and stays set until the next start. The word count then reads DEPTH. Later words overwrite the oldest ones, and the read pointer follows the write pointer, so that readout begins at the oldest surviving word.
- R5: A read of index 6 (data) while ready and in ring mode behaves as follows. With a non-zero count, it returns the word at the read pointer, advances the pointer by 4 bytes and decrements the count. With a zero count, it returns 0xFFFFFFFF and leaves the read pointer unchanged.
- R6: A write to index 4 while ready behaves as follows. Address bits below the frame alignment are cleared: 16 bytes, or 32 bytes when MEM_W is 256. The count becomes the circular word distance from the read pointer to the write pointer, or DEPTH when that distance is 0 and full is set. The write pointer and the full flag keep their values.
- R7: A write to index 5 while ready sets the write pointer, with bits 1:0 cleared. The count is recomputed with the same distance rule.
- R8: Writing 1 to bit 1 of index 0 during capture stops it. Words accepted before the command are still stored. Status bit 0 reads 0 for the two cycles after the command and reads 1 from the third cycle on.
- R9: The first trigger pulse during capture latches index 3 (trigger count, N) and sets status bit 2. Exactly N more words after the trigger cycle are stored, and then capture stops by itself.
- R10: With mode bit 0 set to 1 (pass-through), accepted words appear in order on fifo_data_o with fifo_valid_o high one cycle after acceptance. The RAM, the pointers and the count stay untouched, and a data read returns 0xFFFFFFFF.
- R11: While not ready, writes to index 1 have no effect. A data read returns 0xFFFFFFFF and leaves the read pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trc_valid_i | input | 1 | Trace word valid |
| trc_data_i | input | 32 | Trace word |
| trig_i | input | 1 | Trigger event |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_idx_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid the cycle after reg_re_i |
| fifo_valid_o | output | 1 | Pass-through word valid |
| fifo_data_o | output | 32 | Pass-through word |

## Verification
The capture path is exercised with four kinds of input:
- A short burst that stays below the RAM size. This separates the plain circular distance from the full rule.
- A burst 10 words past the RAM size. This shows whether the read pointer follows the write pointer and whether readout starts at the oldest surviving word rather than at address 0.
- A continuous stream with a mid-stream trigger. This pins the stop point to exactly the trigger word plus the programmed count.
- A pass-through burst. This proves that the words bypass the RAM.

Pointer writes with misaligned values, made while the full flag is set, show that the alignment mask and the recomputed count follow the distance rule. Reads past the end of the data, and reads made during capture, show that the all-ones word is returned and that the pointer does not move.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_HALT  = 2'd3
  } cap_state_e;

  typedef enum logic [2:0] {
    IDX_CTRL  = 3'd0,
    IDX_MODE  = 3'd1,
    IDX_STAT  = 3'd2,
    IDX_TRG   = 3'd3,
    IDX_RPTR  = 3'd4,
    IDX_WPTR  = 3'd5,
    IDX_RDATA = 3'd6,
    IDX_AVAIL = 3'd7
  } reg_idx_e;

  localparam logic [31:0] DRAINED_WORD = 32'hFFFF_FFFF;
endpackage

// File: rtl/tcb_ram.sv
module tcb_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tcb_ctrl.sv
module tcb_ctrl
  import tcb_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             trc_valid_i,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] trg_cnt_i,
  output logic             accept_o,
  output logic             ready_o,
  output logic             triggered_o,
  output cap_state_e       state_o
);
  cap_state_e       state_q, state_d;
  logic             trig_q;
  logic [CNT_W-1:0] rem_q;
  logic             exhausted;

  assign exhausted = trig_q && (rem_q == '0);
  assign accept_o  = (state_q == ST_RUN) && trc_valid_i && !stop_i && !exhausted;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_RUN;
      ST_RUN:   if (stop_i || exhausted) state_d = ST_DRAIN;
      ST_DRAIN: state_d = ST_HALT;
      ST_HALT:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      trig_q  <= 1'b0;
      rem_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) begin
        trig_q <= 1'b0;
        rem_q  <= '0;
      end else if (state_q == ST_RUN && !stop_i) begin
        if (trig_i && !trig_q) begin
          trig_q <= 1'b1;
          rem_q  <= trg_cnt_i;
        end else if (trig_q && accept_o) begin
          rem_q <= rem_q - 1'b1;
        end
      end
    end
  end

  assign ready_o     = (state_q == ST_IDLE);
  assign triggered_o = trig_q;
  assign state_o     = state_q;

  // R8: drain lasts one cycle, then one halt cycle, then ready
  a_r8_drain_to_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DRAIN |=> state_q == ST_HALT);
  a_r8_halt_to_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_HALT |=> ready_o);
  // R9: count exhausted ends the run
  a_r9_exhaust_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && trig_q && rem_q == '0) |=> state_q == ST_DRAIN);
  // R9: trigger flag holds until a new start
  a_r9_trig_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q && !start_i) |=> trig_q);
endmodule

// File: rtl/tcb_ptrs.sv
module tcb_ptrs #(
  parameter int DEPTH = 64,
  parameter int MEM_W = 32,
  parameter int PW    = $clog2(DEPTH) + 2,
  parameter int AW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic          pop_i,
  input  logic          rptr_we_i,
  input  logic          wptr_we_i,
  input  logic [PW-1:0] ptr_wdata_i,
  output logic [PW-1:0] rptr_o,
  output logic [PW-1:0] wptr_o,
  output logic          full_o,
  output logic [AW-1:0] avail_o,
  output logic          pop_hit_o
);
  localparam int IW   = PW - 2;
  localparam int ALSB = (MEM_W == 256) ? 5 : 4;
  localparam logic [PW-1:0] RMASK = ~PW'((1 << ALSB) - 1);
  localparam logic [PW-1:0] WMASK = ~PW'(3);
  localparam logic [AW-1:0] FULL_CNT = AW'(DEPTH);

  logic [PW-1:0] rptr_q, wptr_q, wnext, rptr_new, wptr_new;
  logic          full_q, wrap;
  logic [AW-1:0] avail_q;

  function automatic logic [AW-1:0] span(logic [PW-1:0] w, logic [PW-1:0] r, logic f);
    logic [IW-1:0] d;
    d = w[PW-1:2] - r[PW-1:2];
    if (d == '0 && f) return FULL_CNT;
    return AW'(d);
  endfunction

  assign wnext     = wptr_q + PW'(4);
  assign wrap      = (wnext == '0);
  assign rptr_new  = ptr_wdata_i & RMASK;
  assign wptr_new  = ptr_wdata_i & WMASK;
  assign pop_hit_o = pop_i && (avail_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      wptr_q  <= '0;
      full_q  <= 1'b0;
      avail_q <= '0;
    end else if (clr_i) begin
      rptr_q  <= '0;
      wptr_q  <= '0;
      full_q  <= 1'b0;
      avail_q <= '0;
    end else if (wr_i) begin
      wptr_q <= wnext;
      if (wrap || full_q) begin
        rptr_q  <= wnext;  // oldest surviving word
        full_q  <= 1'b1;
        avail_q <= FULL_CNT;
      end else begin
        avail_q <= avail_q + 1'b1;
      end
    end else if (pop_hit_o) begin
      rptr_q  <= rptr_q + PW'(4);
      avail_q <= avail_q - 1'b1;
    end else if (rptr_we_i) begin
      rptr_q  <= rptr_new;
      avail_q <= span(wptr_q, rptr_new, full_q);
    end else if (wptr_we_i) begin
      wptr_q  <= wptr_new;
      avail_q <= span(wptr_new, rptr_q, full_q);
    end
  end

  assign rptr_o  = rptr_q;
  assign wptr_o  = wptr_q;
  assign full_o  = full_q;
  assign avail_o = avail_q;

  a_r2_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (wptr_q == '0 && rptr_q == '0 && !full_q && avail_q == '0));
  a_r4_full_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !clr_i) |=> full_q);
  a_r4_rptr_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && wr_i && !clr_i) |=> (rptr_q == wptr_q && avail_q == FULL_CNT));
  a_r5_empty_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && avail_q == '0 && !wr_i && !clr_i && !rptr_we_i) |=> $stable(rptr_q));
  a_r3_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avail_q <= FULL_CNT);
  a_r6_wptr_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rptr_we_i && !wr_i && !clr_i && !pop_hit_o) |=> ($stable(wptr_q) && $stable(full_q)));
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
  import tcb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int MEM_W = 32,
  parameter int CNT_W = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        trc_valid_i,
  input  logic [31:0] trc_data_i,
  input  logic        trig_i,
  input  logic        reg_we_i,
  input  logic        reg_re_i,
  input  logic [2:0]  reg_idx_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        fifo_valid_o,
  output logic [31:0] fifo_data_o
);
  localparam int PW = $clog2(DEPTH) + 2;
  localparam int AW = $clog2(DEPTH + 1);
  localparam int IW = PW - 2;

  reg_idx_e         idx;
  cap_state_e       state;
  logic             ready, trig_seen, accept;
  logic             start, stop, pop_req, pop_hit;
  logic             mode_q;
  logic [CNT_W-1:0] trg_cnt_q;
  logic             st_vld_q;
  logic [31:0]      st_dat_q, ram_rd, rdata_q;
  logic             ram_we;
  logic [PW-1:0]    rptr, wptr;
  logic             full;
  logic [AW-1:0]    avail;

  assign idx     = reg_idx_e'(reg_idx_i);
  assign start   = reg_we_i && idx == IDX_CTRL && reg_wdata_i[0] && ready;
  assign stop    = reg_we_i && idx == IDX_CTRL && reg_wdata_i[1];
  assign pop_req = reg_re_i && idx == IDX_RDATA && ready && !mode_q;

  tcb_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .stop_i      (stop),
    .trc_valid_i (trc_valid_i),
    .trig_i      (trig_i),
    .trg_cnt_i   (trg_cnt_q),
    .accept_o    (accept),
    .ready_o     (ready),
    .triggered_o (trig_seen),
    .state_o     (state)
  );

  // one-word input stage, emptied during the drain cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_vld_q <= 1'b0;
      st_dat_q <= '0;
    end else begin
      st_vld_q <= accept;
      if (accept) st_dat_q <= trc_data_i;
    end
  end

  assign ram_we       = st_vld_q && !mode_q;
  assign fifo_valid_o = st_vld_q && mode_q;
  assign fifo_data_o  = st_dat_q;

  tcb_ptrs #(.DEPTH(DEPTH), .MEM_W(MEM_W), .PW(PW), .AW(AW)) u_ptrs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (start),
    .wr_i        (ram_we),
    .pop_i       (pop_req),
    .rptr_we_i   (reg_we_i && idx == IDX_RPTR && ready),
    .wptr_we_i   (reg_we_i && idx == IDX_WPTR && ready),
    .ptr_wdata_i (reg_wdata_i[PW-1:0]),
    .rptr_o      (rptr),
    .wptr_o      (wptr),
    .full_o      (full),
    .avail_o     (avail),
    .pop_hit_o   (pop_hit)
  );

  tcb_ram #(.DEPTH(DEPTH), .DW(32), .IW(IW)) u_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .waddr_i (wptr[PW-1:2]),
    .wdata_i (st_dat_q),
    .raddr_i (rptr[PW-1:2]),
    .rdata_o (ram_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= 1'b0;
      trg_cnt_q <= '0;
    end else if (reg_we_i && ready) begin
      if (idx == IDX_MODE) mode_q    <= reg_wdata_i[0];
      if (idx == IDX_TRG)  trg_cnt_q <= reg_wdata_i[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (reg_re_i) begin
      unique case (idx)
        IDX_CTRL:  rdata_q <= {31'd0, !ready};
        IDX_MODE:  rdata_q <= {31'd0, mode_q};
        IDX_STAT:  rdata_q <= {29'd0, trig_seen, full, ready};
        IDX_TRG:   rdata_q <= 32'(trg_cnt_q);
        IDX_RPTR:  rdata_q <= 32'(rptr);
        IDX_WPTR:  rdata_q <= 32'(wptr);
        IDX_RDATA: rdata_q <= pop_hit ? ram_rd : DRAINED_WORD;
        IDX_AVAIL: rdata_q <= 32'(avail);
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata_o = rdata_q;

  // R10: pass-through never touches the RAM
  a_r10_no_ram_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |-> !ram_we);
  // R11: mode frozen while capture is in progress
  a_r11_mode_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready |=> $stable(mode_q));
  // R2: no ready while running
  a_r2_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_RUN |-> !ready);
endmodule

// File: tb/sim_trace_capture_buf.sv
`timescale 1ns/1ps
module sim_trace_capture_buf;
  localparam int DEPTH = 64;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trc_valid = 1'b0;
  logic [31:0] trc_data = '0;
  logic        trig = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [2:0]  idx = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fifo_valid;
  logic [31:0] fifo_data;

  int n_tests = 0, n_fail = 0, cyc = 0;
  logic [31:0] exp_q[$];
  logic [31:0] fifo_q[$];
  int fifo_seen = 0;

  always #2 clk = ~clk;

  trace_capture_buf #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .trc_valid_i(trc_valid), .trc_data_i(trc_data),
    .trig_i(trig), .reg_we_i(we), .reg_re_i(re), .reg_idx_i(idx),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .fifo_valid_o(fifo_valid),
    .fifo_data_o(fifo_data)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(logic [2:0] i, logic [31:0] d);
    @(negedge clk); we = 1'b1; idx = i; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic reg_rd(logic [2:0] i, output logic [31:0] d);
    @(negedge clk); re = 1'b1; idx = i;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic rd_chk(string req, string what, logic [2:0] i, logic [31:0] exp);
    logic [31:0] d;
    reg_rd(i, d);
    chk(req, what, d, exp);
  endtask

  // driver: stream words, record expectations (ring model keeps last DEPTH)
  task automatic push_words(int n, logic [31:0] base, bit to_fifo);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); trc_valid = 1'b1; trc_data = base + k;
      if (to_fifo) fifo_q.push_back(base + k);
      else begin
        exp_q.push_back(base + k);
        if (exp_q.size() > DEPTH) void'(exp_q.pop_front());
      end
    end
    @(negedge clk); trc_valid = 1'b0;
  endtask

  task automatic drain_chk(string req, int n);
    logic [31:0] d, e;
    for (int k = 0; k < n; k++) begin
      reg_rd(3'd6, d);
      e = (exp_q.size() != 0) ? exp_q.pop_front() : ONES;
      chk(req, "readout word", d, e);
    end
  endtask

  // monitor: pass-through scoreboard
  always @(negedge clk) begin
    if (rst_n && fifo_valid) begin
      fifo_seen++;
      if (fifo_q.size() == 0) chk("R10", "unexpected fifo word", fifo_data, ONES);
      else chk("R10", "fifo word", fifo_data, fifo_q.pop_front());
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL R8 watchdog: actual=%0d cycles expected<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk("R1", "status", 3'd2, 32'h1);
    rd_chk("R1", "rptr", 3'd4, 0);
    rd_chk("R1", "wptr", 3'd5, 0);
    rd_chk("R1", "count", 3'd7, 0);
    rd_chk("R1", "mode", 3'd1, 0);
    rd_chk("R5", "empty read", 3'd6, ONES);

    // short burst
    reg_wr(3'd0, 32'h1);
    rd_chk("R2", "status busy", 3'd2, 32'h0);
    push_words(12, 32'hA000_0000, 1'b0);
    reg_wr(3'd1, 32'h1);
    rd_chk("R11", "read during capture", 3'd6, ONES);
    reg_wr(3'd0, 32'h2);
    rd_chk("R8", "not ready right after stop", 3'd2, 32'h0);
    reg_rd(3'd2, d);
    rd_chk("R8", "ready on third cycle", 3'd2, 32'h1);
    rd_chk("R11", "mode write ignored", 3'd1, 0);
    rd_chk("R11", "rptr unmoved", 3'd4, 0);
    rd_chk("R3", "count", 3'd7, 12);
    rd_chk("R3", "wptr", 3'd5, 48);
    drain_chk("R5", 12);
    rd_chk("R5", "read past end", 3'd6, ONES);
    rd_chk("R5", "rptr held", 3'd4, 48);
    rd_chk("R5", "count zero", 3'd7, 0);

    // wrap burst
    reg_wr(3'd0, 32'h1);
    rd_chk("R2", "wptr cleared", 3'd5, 0);
    rd_chk("R2", "count cleared", 3'd7, 0);
    push_words(DEPTH + 10, 32'hB000_0000, 1'b0);
    reg_wr(3'd0, 32'h2);
    repeat (4) @(negedge clk);
    rd_chk("R4", "status full", 3'd2, 32'h3);
    rd_chk("R4", "count full", 3'd7, DEPTH);
    rd_chk("R4", "rptr at oldest", 3'd4, 40);
    rd_chk("R4", "wptr", 3'd5, 40);
    drain_chk("R4", DEPTH);
    rd_chk("R4", "drained", 3'd6, ONES);

    // R6: misaligned rptr 0x2B -> 0x20 (word 8), wptr word 10
    reg_wr(3'd4, 32'h2B);
    rd_chk("R6", "rptr aligned", 3'd4, 32'h20);
    rd_chk("R6", "count distance", 3'd7, 2);
    rd_chk("R6", "wptr kept", 3'd5, 40);
    rd_chk("R6", "full kept", 3'd2, 32'h3);
    exp_q.push_back(32'hB000_0000 + 72);
    exp_q.push_back(32'hB000_0000 + 73);
    drain_chk("R6", 3);

    // R7: wptr 0x33 -> 0x30 (word 12), rptr now word 10
    reg_wr(3'd5, 32'h33);
    rd_chk("R7", "wptr aligned", 3'd5, 32'h30);
    rd_chk("R7", "count distance", 3'd7, 2);
    exp_q.push_back(32'hB000_0000 + 10);
    exp_q.push_back(32'hB000_0000 + 11);
    drain_chk("R7", 2);
    reg_wr(3'd4, 32'h30);
    rd_chk("R6", "zero distance while full", 3'd7, DEPTH);

    // R9 trigger: count 5, trigger on word 7 -> words 0..12 kept
    reg_wr(3'd3, 32'd5);
    reg_wr(3'd0, 32'h1);
    exp_q.delete();
    for (int k = 0; k <= 12; k++) exp_q.push_back(32'hC000_0000 + k);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk); trc_valid = 1'b1; trc_data = 32'hC000_0000 + k; trig = (k == 7);
    end
    @(negedge clk); trc_valid = 1'b0; trig = 1'b0;
    repeat (4) @(negedge clk);
    rd_chk("R9", "status stopped+triggered", 3'd2, 32'h5);
    rd_chk("R9", "count", 3'd7, 13);
    drain_chk("R9", 14);

    // R10 pass-through
    reg_wr(3'd3, 32'd0);
    reg_wr(3'd1, 32'h1);
    reg_wr(3'd0, 32'h1);
    push_words(6, 32'hD000_0000, 1'b1);
    reg_wr(3'd0, 32'h2);
    repeat (4) @(negedge clk);
    chk("R10", "fifo words seen", fifo_seen, 6);
    chk("R10", "fifo queue empty", fifo_q.size(), 0);
    rd_chk("R10", "count untouched", 3'd7, 0);
    rd_chk("R10", "wptr untouched", 3'd5, 0);
    rd_chk("R10", "data read", 3'd6, ONES);
    reg_wr(3'd1, 32'h0);
    rd_chk("R1", "mode back to ring", 3'd1, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule